// File: doc/BRIEF.md
# Address-Range Watchpoint Unit

This block watches the addresses a processor core fetches instructions from and the addresses it reads or writes data at. It checks them against a small bank of programmable watchpoints. Each watchpoint holds a base address, a bit mask and three stream enables. An access hits a watchpoint when the masked access address equals the masked base. A single base/mask pair therefore covers any aligned power-of-two range, and a full mask narrows it to a single address.

A hit becomes a one-cycle request to the core, registered one cycle after the access. When the debug-enable input is low the request goes out as a trap. When it is high the same hit asks for entry into debug mode instead. The index of the winning watchpoint travels with the request. Software configures the bank through a simple word-wide write/read port.

Top module: `addr_watch_unit`

## Requirements
- R1: The parameter NUM_WP (1 to 4) sets how many watchpoints exist. Register slots with an index of NUM_WP or higher read as zero, and writes to them have no effect.
- R2: Register select `cfg_addr[3:2]` picks the watchpoint and `cfg_addr[1:0]` picks the field: 0 is base, 1 is mask, 2 is control, and 3 is unused and reads zero. In the control field, bit 0 enables instruction fetch, bit 1 enables data load and bit 2 enables data store. `cfg_rdata` returns the selected field combinationally.
- R3: An address matches a watchpoint when `(addr & mask) == (base & mask)`.
- R4: A fetch address is checked only while `fetch_valid` is high and the fetch enable is set. A data address is checked only while `data_valid` is high. It is checked against the load enable when `data_write` is 0 and against the store enable when `data_write` is 1. A watchpoint with all enables clear never fires.
- R5: A hit with `dbg_en` low raises `trap_req`. A hit with `dbg_en` high raises `debug_req` instead. The two are never high together.
- R6: When several watchpoints hit in the same cycle, the lowest index wins and is reported on `hit_idx`. `hit_idx` is 0 whenever no request is raised.
- R7: Requests appear in the cycle after the clock edge that samples the access, and they last one cycle unless the next access also hits.
- R8: Reset clears every base, mask and control field and drives both requests low. Reset is asserted asynchronously and released after two clock edges.
- R9: A configuration write takes effect for accesses sampled at later edges. An access sampled at the same edge as the write sees the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Watchpoint index and field select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected field read data |
| fetch_valid | input | 1 | Instruction fetch address is valid |
| fetch_addr | input | 32 | Instruction fetch address |
| data_valid | input | 1 | Data access address is valid |
| data_addr | input | 32 | Data access address |
| data_write | input | 1 | 1 for a store, 0 for a load |
| dbg_en | input | 1 | Debug unit present and enabled |
| trap_req | output | 1 | Trap request pulse |
| debug_req | output | 1 | Debug-mode entry request pulse |
| hit_idx | output | 2 | Index of the winning watchpoint |

## Verification
The bench places overlapping ranges so that two watchpoints hit at once. A priority encoder that picked the highest index would then report 2 instead of 0. It drives loads and stores at a load-only watchpoint and fetches at data-only ones. A design that mixed up the stream enables would fire on the wrong access type. Addresses one below and one above each range edge expose a mask applied to only one side of the compare. A write issued in the same cycle as a matching fetch shows whether new settings leak into an access that was already sampled. A second instance with two watchpoints shows whether slots beyond NUM_WP can be written or read back.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int WP_MAX = 4;
  localparam int IDX_W  = 2;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } wp_field_e;

  typedef struct packed {
    logic st_en;
    logic ld_en;
    logic fe_en;
  } wp_ctrl_t;
endpackage

// File: rtl/wpu_regfile.sv
module wpu_regfile
  import wpu_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int AW     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W+1:0]              addr,
  input  logic [AW-1:0]                 wdata,
  output logic [AW-1:0]                 rdata,
  output logic [NUM_WP-1:0][AW-1:0]     base_o,
  output logic [NUM_WP-1:0][AW-1:0]     mask_o,
  output wp_ctrl_t [NUM_WP-1:0]         ctrl_o
);
  logic [IDX_W-1:0] sel_idx;
  wp_field_e        sel_fld;

  assign sel_idx = addr[IDX_W+1:2];
  assign sel_fld = wp_field_e'(addr[1:0]);

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic [AW-1:0] base_q, base_d, mask_q, mask_d;
    wp_ctrl_t      ctrl_q, ctrl_d;
    logic          hit_sel;

    assign hit_sel = we && (sel_idx == IDX_W'(g));

    always_comb begin
      base_d = base_q;
      mask_d = mask_q;
      ctrl_d = ctrl_q;
      if (hit_sel) begin
        case (sel_fld)
          FLD_BASE: base_d = wdata;
          FLD_MASK: mask_d = wdata;
          FLD_CTRL: ctrl_d = wp_ctrl_t'(wdata[2:0]);
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        ctrl_q <= '0;
      end else if (hit_sel) begin
        base_q <= base_d;
        mask_q <= mask_d;
        ctrl_q <= ctrl_d;
      end
    end

    assign base_o[g] = base_q;
    assign mask_o[g] = mask_q;
    assign ctrl_o[g] = ctrl_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (sel_idx == IDX_W'(i)) begin
        case (sel_fld)
          FLD_BASE: rdata = base_o[i];
          FLD_MASK: rdata = mask_o[i];
          FLD_CTRL: rdata = AW'(ctrl_o[i]);
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wpu_compare.sv
module wpu_compare
  import wpu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  wp_ctrl_t      ctrl,
  input  logic          fe_valid,
  input  logic [AW-1:0] fe_addr,
  input  logic          dt_valid,
  input  logic [AW-1:0] dt_addr,
  input  logic          dt_write,
  output logic          hit
);
  logic [AW-1:0] ref_m;
  logic          fe_match, dt_match, dt_allow;

  assign ref_m    = base & mask;
  assign fe_match = (fe_addr & mask) == ref_m;
  assign dt_match = (dt_addr & mask) == ref_m;
  assign dt_allow = dt_write ? ctrl.st_en : ctrl.ld_en;

  assign hit = (fe_valid && ctrl.fe_en && fe_match) ||
               (dt_valid && dt_allow && dt_match);
endmodule

// File: rtl/wpu_prio.sv
module wpu_prio
  import wpu_pkg::*;
#(
  parameter int NUM_WP = 4
) (
  input  logic [NUM_WP-1:0] hits,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
  assign any = |hits;
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import wpu_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int AW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          data_valid,
  input  logic [AW-1:0] data_addr,
  input  logic          data_write,
  input  logic          dbg_en,
  output logic          trap_req,
  output logic          debug_req,
  output logic [1:0]    hit_idx
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_WP-1:0][AW-1:0] wp_base, wp_mask;
  wp_ctrl_t [NUM_WP-1:0]     wp_ctrl;
  logic [NUM_WP-1:0]         wp_hit;
  logic                      any_hit;
  logic [IDX_W-1:0]          win_idx;

  wpu_regfile #(.NUM_WP(NUM_WP), .AW(AW)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .base_o(wp_base), .mask_o(wp_mask), .ctrl_o(wp_ctrl)
  );

  for (genvar g = 0; g < NUM_WP; g++) begin : g_cmp
    wpu_compare #(.AW(AW)) i_cmp (
      .base(wp_base[g]), .mask(wp_mask[g]), .ctrl(wp_ctrl[g]),
      .fe_valid(fetch_valid), .fe_addr(fetch_addr),
      .dt_valid(data_valid), .dt_addr(data_addr), .dt_write(data_write),
      .hit(wp_hit[g])
    );
  end

  wpu_prio #(.NUM_WP(NUM_WP)) i_prio (
    .hits(wp_hit), .any(any_hit), .idx(win_idx)
  );

  logic             trap_d, dbg_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    trap_d = any_hit && !dbg_en;
    dbg_d  = any_hit &&  dbg_en;
    idx_d  = any_hit ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trap_req  <= 1'b0;
      debug_req <= 1'b0;
      hit_idx   <= '0;
    end else begin
      trap_req  <= trap_d;
      debug_req <= dbg_d;
      hit_idx   <= idx_d;
    end
  end
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker #(
  parameter int NUM_WP = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_valid,
  input logic       data_valid,
  input logic       dbg_en,
  input logic       trap_req,
  input logic       debug_req,
  input logic [1:0] hit_idx
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && debug_req)); // R5
  AST_DEBUG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |-> $past(dbg_en)); // R5
  AST_TRAP_NEEDS_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !$past(dbg_en)); // R5
  AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req || debug_req) |-> hit_idx == 2'd0); // R6
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hit_idx) < NUM_WP); // R1
  AST_REQ_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || debug_req) |-> $past(fetch_valid || data_valid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid || data_valid) |=> !(trap_req || debug_req)); // R7
endmodule

bind addr_watch_unit wpu_checker #(.NUM_WP(NUM_WP)) i_wpu_checker (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
  .data_valid(data_valid), .dbg_en(dbg_en), .trap_req(trap_req),
  .debug_req(debug_req), .hit_idx(hit_idx)
);

// File: tb/test_addr_watch_unit.sv
module test_addr_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, s_we;
  logic [3:0]  cfg_addr, s_addr;
  logic [31:0] cfg_wdata, s_wdata, cfg_rdata, s_rdata;
  logic        fetch_valid, data_valid, data_write, dbg_en;
  logic [31:0] fetch_addr, data_addr;
  logic        trap_req, debug_req, s_trap, s_dbg;
  logic [1:0]  hit_idx, s_idx;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  addr_watch_unit i_addr_watch_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .data_valid(data_valid), .data_addr(data_addr), .data_write(data_write),
    .dbg_en(dbg_en), .trap_req(trap_req), .debug_req(debug_req), .hit_idx(hit_idx)
  );

  addr_watch_unit #(.NUM_WP(2)) i_addr_watch_unit_n2 (
    .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_addr(s_addr),
    .cfg_wdata(s_wdata), .cfg_rdata(s_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .data_valid(data_valid), .data_addr(data_addr), .data_write(data_write),
    .dbg_en(dbg_en), .trap_req(s_trap), .debug_req(s_dbg), .hit_idx(s_idx)
  );

  typedef struct packed {
    logic fv; logic [31:0] fa; logic dv; logic [31:0] da; logic dw; logic de;
    logic et; logic ed; logic [1:0] ei;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1234, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
    '{1'b1, 32'h0000_1850, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
    '{1'b1, 32'h0000_2010, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 32'h0,         1'b1, 32'h0000_2044, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    '{1'b0, 32'h0,         1'b1, 32'h0000_2044, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 32'h0,         1'b1, 32'h0000_18FF, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2},
    '{1'b0, 32'h0,         1'b1, 32'h0000_1900, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 32'h0,         1'b1, 32'h8ABC_0000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3},
    '{1'b0, 32'h0,         1'b1, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 32'h0000_1FFF, 1'b1, 32'h9000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    '{1'b1, 32'h0000_2000, 1'b1, 32'h0000_1801, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2},
    '{1'b1, 32'h0000_0FFF, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 32'h0000_1234, 1'b0, 32'h0000_2044, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic t, input logic d, input logic [1:0] i);
    check(tag, {29'd0, trap_req, debug_req, hit_idx}, {29'd0, t, d, i});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle_access();
    fetch_valid = 1'b0; data_valid = 1'b0; data_write = 1'b0; dbg_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    s_we = 1'b0; s_addr = '0; s_wdata = '0;
    fetch_addr = '0; data_addr = '0;
    idle_access();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check_out("R8 outputs after reset", 1'b0, 1'b0, 2'd0);
    for (int a = 0; a < 16; a++) begin
      cfg_addr = 4'(a);
      #1 check("R8 register cleared", cfg_rdata, 32'h0);
    end

    // Configure: {idx, field}; field 0 base, 1 mask, 2 ctrl {st,ld,fe}
    wr(4'b00_00, 32'h0000_1000); wr(4'b00_01, 32'hFFFF_F000); wr(4'b00_10, 32'h1);
    wr(4'b01_00, 32'h0000_2000); wr(4'b01_01, 32'hFFFF_FF00); wr(4'b01_10, 32'h2);
    wr(4'b10_00, 32'h0000_1800); wr(4'b10_01, 32'hFFFF_FF00); wr(4'b10_10, 32'h5);
    wr(4'b11_00, 32'h8000_0000); wr(4'b11_01, 32'hF000_0000); wr(4'b11_10, 32'h6);
    wr(4'b11_11, 32'hDEAD_BEEF);

    // R2: readback
    cfg_addr = 4'b01_00; #1 check("R2 base readback", cfg_rdata, 32'h0000_2000);
    cfg_addr = 4'b10_01; #1 check("R2 mask readback", cfg_rdata, 32'hFFFF_FF00);
    cfg_addr = 4'b11_10; #1 check("R2 ctrl readback", cfg_rdata, 32'h6);
    cfg_addr = 4'b11_11; #1 check("R2 unused field reads zero", cfg_rdata, 32'h0);

    // Vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      fetch_valid = VECS[v].fv; fetch_addr = VECS[v].fa;
      data_valid = VECS[v].dv; data_addr = VECS[v].da;
      data_write = VECS[v].dw; dbg_en = VECS[v].de;
      @(negedge clk);
      check_out($sformatf("R3 R4 R5 R6 vector %0d", v), VECS[v].et, VECS[v].ed, VECS[v].ei);
    end

    // R7: single-cycle pulse
    fetch_valid = 1'b1; fetch_addr = 32'h0000_1004; data_valid = 1'b0; dbg_en = 1'b0;
    @(negedge clk);
    check_out("R7 pulse raised", 1'b1, 1'b0, 2'd0);
    idle_access();
    @(negedge clk);
    check_out("R7 pulse ends", 1'b0, 1'b0, 2'd0);

    // R9: write in the same cycle as a matching fetch uses the old control
    cfg_we = 1'b1; cfg_addr = 4'b01_10; cfg_wdata = 32'h3;
    fetch_valid = 1'b1; fetch_addr = 32'h0000_2010;
    @(negedge clk);
    cfg_we = 1'b0;
    check_out("R9 old setting for same-cycle access", 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check_out("R9 new setting applies next", 1'b1, 1'b0, 2'd1);
    idle_access();

    // R4: all enables clear never fires
    wr(4'b00_10, 32'h0);
    fetch_valid = 1'b1; fetch_addr = 32'h0000_1234;
    @(negedge clk);
    check_out("R4 disabled watchpoint silent", 1'b0, 1'b0, 2'd0);
    idle_access();

    // R1: two-watchpoint instance
    @(negedge clk);
    s_we = 1'b1; s_addr = 4'b10_00; s_wdata = 32'h1234_5678;
    @(negedge clk);
    s_addr = 4'b01_00; s_wdata = 32'hCAFE_0000;
    @(negedge clk);
    s_we = 1'b0;
    s_addr = 4'b10_00; #1 check("R1 slot above NUM_WP reads zero", s_rdata, 32'h0);
    s_addr = 4'b01_00; #1 check("R1 present slot readback", s_rdata, 32'hCAFE_0000);

    // R8: reset mid-run clears the bank
    do_reset();
    cfg_addr = 4'b10_00; #1 check("R8 base cleared", cfg_rdata, 32'h0);
    cfg_addr = 4'b01_10; #1 check("R8 ctrl cleared", cfg_rdata, 32'h0);
    fetch_valid = 1'b1; fetch_addr = 32'h0000_2010;
    data_valid = 1'b1; data_addr = 32'h8000_0000; data_write = 1'b1;
    @(negedge clk);
    check_out("R8 no hits after reset", 1'b0, 1'b0, 2'd0);
    idle_access();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule